// File: doc/BRIEF.md
# Spare Row and Column Address Remapper

This block sits between a memory client and a bitcell array of 256 rows by 256 columns, which also has two spare rows and two spare columns. Each request carries a logical row and a logical column. Both are looked up at the same time in two small repair tables, one for rows and one for columns. A row that matches a live entry is steered to the spare row that entry names. A column that matches is steered to the named spare column. An access can therefore land on the main array, on a spare row, on a spare column, or on the cell where a spare row crosses a spare column. An address that matches nothing passes through unchanged. The array is a behavioural RAM of 258 by 258 one-bit cells: physical rows and columns 0 to 255 are the main array, and 256 plus the spare index selects a spare.

After reset the block reads its repair entries from a fuse-word image, one word per cycle. It holds the request channel not-ready until every word has been loaded, so the map is in force before the first user access. Once loading is done, single entries can be overwritten through a plain configuration port. This soft repair lets a candidate map be tried out before it is made permanent.

The request channel is valid/ready. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. The client must hold its request until it is taken. `req_ready` is low only while the fuse image is loading. The response channel has no back-pressure. It presents one beat, the cycle after each accepted request. The beat carries the physical row and column that were used, and for reads the stored bit.

An entry is 10 bits wide: bit 9 is valid, bit 8 is the spare index, and bits 7:0 are the faulty address. Fuse words and configuration entries use the same layout.

Top module: `spare_remap_top`

## Requirements
- R1: After reset, `req_ready` stays low and no request is taken while the fuse image loads. `req_ready` goes high 2*N_ENT cycles after reset is released (4 cycles by default) and stays high.
- R2: Fuse words are read at `fuse_addr` 0 to 2*N_ENT-1. Words 0 to N_ENT-1 fill row entries 0 to N_ENT-1. The remaining words fill column entries 0 to N_ENT-1. Each word uses the 10-bit entry layout.
- R3: If the request row matches the address of a valid row entry, the response row is 256 plus that entry's spare index. Otherwise the response row equals the request row.
- R4: If the request column matches the address of a valid column entry, the response column is 256 plus that entry's spare index. Otherwise the response column equals the request column.
- R5: When both the row and the column are remapped, the access uses the cell at the crossing of the spare row and the spare column. That cell stores data separately from the same spare row with an unremapped column, and from the same spare column with an unremapped row.
- R6: A configuration write (`cfg_we` high, `cfg_col` = 0 for the row table or 1 for the column table, `cfg_idx` = entry number) replaces that entry at the clock edge. A request taken on the same edge still uses the old map. Requests taken later use the new map.
- R7: If two valid entries in one table name the same spare, that table's error flag (`row_cfg_err` or `col_cfg_err`) is high. That table then remaps nothing. The other table is unaffected.
- R8: If several valid entries in one table match the same address, the entry with the lowest index decides the spare.
- R9: Every accepted request gives exactly one response beat, on the next cycle, and no beat appears otherwise. A read returns the bit last written to the same physical cell. A write returns `rsp_rdata` = 0.
- R10: An entry whose valid bit is 0 never remaps an address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset; clears all entries and restarts the fuse load |
| fuse_addr | output | 2 | Index of the fuse word being read |
| fuse_word | input | 10 | Fuse word at `fuse_addr`, sampled the same cycle |
| cfg_we | input | 1 | Soft repair write strobe; has no effect while the fuse image loads |
| cfg_col | input | 1 | Table select: 0 = rows, 1 = columns |
| cfg_idx | input | 1 | Entry number in the selected table |
| cfg_entry | input | 10 | New entry: {valid, spare index, address} |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_we | input | 1 | 1 = write, 0 = read |
| req_row | input | 8 | Logical row |
| req_col | input | 8 | Logical column |
| req_wdata | input | 1 | Bit to write |
| rsp_valid | output | 1 | Response beat present |
| rsp_row | output | 9 | Physical row used (256 and up = spare) |
| rsp_col | output | 9 | Physical column used (256 and up = spare) |
| rsp_rdata | output | 1 | Read bit; 0 for writes |
| row_cfg_err | output | 1 | Row table has two valid entries on one spare |
| col_cfg_err | output | 1 | Column table has two valid entries on one spare |

## Verification
The bench builds the block with its default parameters. With these, each table has two entries and there are two spares per dimension, so a single soft write can create or clear a spare collision in one table. The same small tables also allow two live entries on one address, which exercises the lowest-index priority. The full 258 by 258 array is present at this size, so a bench model of the physical array can check reads from the spare row, the spare column and their crossing, as well as reads from the main array.

// File: rtl/remap_pkg.sv
package remap_pkg;
  localparam int unsigned ADDR_W  = 8;
  localparam int unsigned N_SPARE = 2;
  localparam int unsigned SPARE_W = (N_SPARE > 1) ? $clog2(N_SPARE) : 1;
  localparam int unsigned ENTRY_W = 1 + SPARE_W + ADDR_W;
  localparam int unsigned PHYS_W  = ADDR_W + 1;
  localparam int unsigned PHYS_N  = (1 << ADDR_W) + N_SPARE;

  typedef struct packed {
    logic               valid;
    logic [SPARE_W-1:0] spare;
    logic [ADDR_W-1:0]  addr;
  } rep_entry_t;
endpackage

// File: rtl/repair_table.sv
module repair_table
  import remap_pkg::*;
#(
  parameter int unsigned N_ENT = 2,
  localparam int unsigned IW = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IW-1:0]     wr_idx,
  input  rep_entry_t        wr_entry,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic [PHYS_W-1:0] lk_phys,
  output logic              conflict
);
  rep_entry_t tbl [N_ENT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_ENT; i++) tbl[i] <= '0;
    end else if (wr_en) begin
      tbl[wr_idx] <= wr_entry;
    end
  end

  // two live entries sharing one spare make the whole table unusable
  always_comb begin
    conflict = 1'b0;
    for (int i = 0; i < N_ENT; i++)
      for (int j = i + 1; j < N_ENT; j++)
        if (tbl[i].valid && tbl[j].valid && tbl[i].spare == tbl[j].spare)
          conflict = 1'b1;
  end

  logic               hit;
  logic [SPARE_W-1:0] sp;

  // scan downward so the lowest matching index is the last to assign
  always_comb begin
    hit = 1'b0;
    sp  = '0;
    for (int i = N_ENT - 1; i >= 0; i--)
      if (tbl[i].valid && tbl[i].addr == lk_addr) begin
        hit = 1'b1;
        sp  = tbl[i].spare;
      end
  end

  assign lk_phys = (hit && !conflict) ? {1'b1, {(ADDR_W-SPARE_W){1'b0}}, sp}
                                      : {1'b0, lk_addr};
endmodule

// File: rtl/fuse_loader.sv
module fuse_loader
  import remap_pkg::*;
#(
  parameter int unsigned N_ENT = 2,
  localparam int unsigned N_WORDS = 2 * N_ENT,
  localparam int unsigned LW = $clog2(N_WORDS),
  localparam int unsigned IW = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  output logic [LW-1:0]      fuse_addr,
  input  logic [ENTRY_W-1:0] fuse_word,
  output logic               ld_we,
  output logic               ld_col,
  output logic [IW-1:0]      ld_idx,
  output rep_entry_t         ld_entry,
  output logic               done
);
  logic [LW-1:0] cnt;
  logic          loading;
  logic [LW-1:0] offs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      loading <= 1'b1;
    end else if (loading) begin
      if (cnt == LW'(N_WORDS - 1)) loading <= 1'b0;
      else                         cnt     <= cnt + 1'b1;
    end
  end

  assign fuse_addr = cnt;
  assign ld_we     = loading;
  assign ld_col    = (cnt >= LW'(N_ENT));
  assign offs      = ld_col ? (cnt - LW'(N_ENT)) : cnt;
  assign ld_idx    = offs[IW-1:0];
  assign ld_entry  = rep_entry_t'(fuse_word);
  assign done      = !loading;
endmodule

// File: rtl/cell_array.sv
module cell_array #(
  parameter int unsigned ROWS = 258,
  parameter int unsigned COLS = 258,
  parameter int unsigned PW   = 9
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [PW-1:0] row,
  input  logic [PW-1:0] col,
  input  logic          wdata,
  output logic          rdata
);
  logic [COLS-1:0] mem [ROWS];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[row][col] <= wdata;
      else    rdata         <= mem[row][col];
    end
  end
endmodule

// File: rtl/spare_remap_top.sv
module spare_remap_top
  import remap_pkg::*;
#(
  parameter int unsigned N_ENT = 2,
  localparam int unsigned LW = $clog2(2 * N_ENT),
  localparam int unsigned IW = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  output logic [LW-1:0]      fuse_addr,
  input  logic [ENTRY_W-1:0] fuse_word,
  input  logic               cfg_we,
  input  logic               cfg_col,
  input  logic [IW-1:0]      cfg_idx,
  input  logic [ENTRY_W-1:0] cfg_entry,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_we,
  input  logic [ADDR_W-1:0]  req_row,
  input  logic [ADDR_W-1:0]  req_col,
  input  logic               req_wdata,
  output logic               rsp_valid,
  output logic [PHYS_W-1:0]  rsp_row,
  output logic [PHYS_W-1:0]  rsp_col,
  output logic               rsp_rdata,
  output logic               row_cfg_err,
  output logic               col_cfg_err
);
  logic       ld_we, ld_col, done;
  logic [IW-1:0] ld_idx;
  rep_entry_t ld_entry;

  fuse_loader #(.N_ENT(N_ENT)) u_load (
    .clk(clk), .rst_n(rst_n), .fuse_addr(fuse_addr), .fuse_word(fuse_word),
    .ld_we(ld_we), .ld_col(ld_col), .ld_idx(ld_idx), .ld_entry(ld_entry),
    .done(done)
  );

  logic [ADDR_W-1:0] lk_addr [2];
  logic [PHYS_W-1:0] lk_phys [2];
  logic [1:0]        conflict;
  logic [IW-1:0]     wr_idx;
  rep_entry_t        wr_entry;

  assign lk_addr[0] = req_row;
  assign lk_addr[1] = req_col;
  assign wr_idx     = done ? cfg_idx : ld_idx;
  assign wr_entry   = done ? rep_entry_t'(cfg_entry) : ld_entry;

  for (genvar d = 0; d < 2; d++) begin : g_dim
    logic wr_en;
    assign wr_en = done ? (cfg_we && cfg_col == 1'(d)) : (ld_we && ld_col == 1'(d));
    repair_table #(.N_ENT(N_ENT)) u_tbl (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
      .wr_entry(wr_entry), .lk_addr(lk_addr[d]), .lk_phys(lk_phys[d]),
      .conflict(conflict[d])
    );
  end

  assign row_cfg_err = conflict[0];
  assign col_cfg_err = conflict[1];
  assign req_ready   = done;

  logic accept, rsp_is_rd, arr_rdata;
  assign accept = req_valid && req_ready;

  cell_array #(.ROWS(PHYS_N), .COLS(PHYS_N), .PW(PHYS_W)) u_arr (
    .clk(clk), .en(accept), .we(req_we), .row(lk_phys[0]), .col(lk_phys[1]),
    .wdata(req_wdata), .rdata(arr_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_is_rd <= 1'b0;
      rsp_row   <= '0;
      rsp_col   <= '0;
    end else begin
      rsp_valid <= accept;
      if (accept) begin
        rsp_is_rd <= !req_we;
        rsp_row   <= lk_phys[0];
        rsp_col   <= lk_phys[1];
      end
    end
  end

  assign rsp_rdata = rsp_is_rd & arr_rdata;
endmodule

// File: rtl/spare_remap_chk.sv
module spare_remap_chk
  import remap_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_row,
  input logic [ADDR_W-1:0] req_col,
  input logic              rsp_valid,
  input logic [PHYS_W-1:0] rsp_row,
  input logic [PHYS_W-1:0] rsp_col,
  input logic              row_cfg_err,
  input logic              col_cfg_err
);
  // R1
  ready_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> req_ready);

  // R9
  rsp_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  // R9
  rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready) |=> !rsp_valid);

  // R3
  row_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (rsp_row[PHYS_W-1] ? (rsp_row[ADDR_W-1:0] < ADDR_W'(N_SPARE))
                                                    : (rsp_row[ADDR_W-1:0] == $past(req_row))));

  // R4
  col_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (rsp_col[PHYS_W-1] ? (rsp_col[ADDR_W-1:0] < ADDR_W'(N_SPARE))
                                                    : (rsp_col[ADDR_W-1:0] == $past(req_col))));

  // R7
  row_err_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && row_cfg_err) |=> !rsp_row[PHYS_W-1]);

  // R7
  col_err_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && col_cfg_err) |=> !rsp_col[PHYS_W-1]);
endmodule

bind spare_remap_top spare_remap_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_row(req_row), .req_col(req_col), .rsp_valid(rsp_valid),
  .rsp_row(rsp_row), .rsp_col(rsp_col), .row_cfg_err(row_cfg_err),
  .col_cfg_err(col_cfg_err)
);

// File: tb/spare_remap_top_tb.sv
module spare_remap_top_tb;
  localparam int NE = 2;
  localparam int SB = 256;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] fuse_addr;
  logic [9:0] fuse_word;
  logic cfg_we = 0, cfg_col = 0;
  logic [0:0] cfg_idx = '0;
  logic [9:0] cfg_entry = '0;
  logic req_valid = 0, req_we = 0, req_wdata = 0;
  logic [7:0] req_row = '0, req_col = '0;
  logic req_ready, rsp_valid, rsp_rdata, row_cfg_err, col_cfg_err;
  logic [8:0] rsp_row, rsp_col;

  always #2.5ns clk = ~clk;

  logic [9:0] fuse_img [4];
  assign fuse_word = fuse_img[fuse_addr];

  spare_remap_top u_dut (
    .clk(clk), .rst_n(rst_n), .fuse_addr(fuse_addr), .fuse_word(fuse_word),
    .cfg_we(cfg_we), .cfg_col(cfg_col), .cfg_idx(cfg_idx), .cfg_entry(cfg_entry),
    .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
    .req_row(req_row), .req_col(req_col), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_row(rsp_row), .rsp_col(rsp_col),
    .rsp_rdata(rsp_rdata), .row_cfg_err(row_cfg_err), .col_cfg_err(col_cfg_err)
  );

  int checks = 0, errs = 0;
  bit finished = 0;

  logic [9:0]   tbl_m [2][NE];
  logic [257:0] mdl   [258];
  logic [257:0] known [258];
  int hot [4] = '{1, 5, 10, 73};

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit conflict_m(int d);
    for (int i = 0; i < NE; i++)
      for (int j = i + 1; j < NE; j++)
        if (tbl_m[d][i][9] && tbl_m[d][j][9] && tbl_m[d][i][8] == tbl_m[d][j][8]) return 1;
    return 0;
  endfunction

  function automatic int map_m(int d, int a);
    if (conflict_m(d)) return a;
    for (int i = 0; i < NE; i++)
      if (tbl_m[d][i][9] && int'(tbl_m[d][i][7:0]) == a) return SB + int'(tbl_m[d][i][8]);
    return a;
  endfunction

  // one cycle: request (and optional soft write), then check its response
  task automatic access(bit we, int r, int c, bit wd,
                        bit dc = 0, bit cdim = 0, int cidx = 0, logic [9:0] cent = '0);
    bit acc;
    int er, ec, ed;
    bit ek;
    req_valid = 1; req_we = we; req_row = r[7:0]; req_col = c[7:0]; req_wdata = wd;
    cfg_we = dc; cfg_col = cdim; cfg_idx = cidx[0:0]; cfg_entry = cent;
    acc = req_ready;
    er = map_m(0, r); ec = map_m(1, c); ed = 0; ek = 0;
    if (acc) begin
      if (we) begin
        mdl[er][ec] = wd; known[er][ec] = 1'b1; ek = 1;
      end else begin
        ed = int'(mdl[er][ec]); ek = known[er][ec];
      end
    end
    if (dc && req_ready) tbl_m[cdim][cidx] = cent;
    @(negedge clk);
    req_valid = 0; cfg_we = 0;
    chk("R9 response beat", int'(rsp_valid), int'(acc));
    if (acc) begin
      chk("R3 physical row", int'(rsp_row), er);
      chk("R4 physical column", int'(rsp_col), ec);
      if (ek) chk("R9 read data", int'(rsp_rdata), ed);
    end
    chk("R7 row table error flag", int'(row_cfg_err), int'(conflict_m(0)));
    chk("R7 column table error flag", int'(col_cfg_err), int'(conflict_m(1)));
  endtask

  function automatic int pick();
    if ($urandom % 2) return int'($urandom % 256);
    return hot[$urandom % 4];
  endfunction

  initial begin
    int n;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 258; i++) begin mdl[i] = '0; known[i] = '0; end
    fuse_img[0] = {1'b1, 1'b0, 8'd73};
    fuse_img[1] = {1'b1, 1'b1, 8'd10};
    fuse_img[2] = {1'b1, 1'b0, 8'd1};
    fuse_img[3] = {1'b0, 1'b1, 8'd5};
    for (int i = 0; i < NE; i++) begin
      tbl_m[0][i] = fuse_img[i];
      tbl_m[1][i] = fuse_img[NE + i];
    end

    repeat (3) @(negedge clk);
    chk("R1 ready low in reset", int'(req_ready), 0);
    chk("R9 no beat in reset", int'(rsp_valid), 0);
    req_valid = 1; req_we = 1; req_wdata = 1;
    rst_n = 1;
    n = 0;
    while (!req_ready && n < 50) begin
      @(negedge clk);
      n++;
      chk("R1 nothing taken while loading", int'(rsp_valid), 0);
    end
    chk("R1 load length", n, 2 * NE);
    req_valid = 0;
    @(negedge clk);
    chk("R1 ready stays high", int'(req_ready), 1);

    access(1, 5, 5, 1);
    chk("R3 unmatched row passes", int'(rsp_row), 5);
    chk("R4 unmatched column passes", int'(rsp_col), 5);
    access(1, 73, 20, 1);
    chk("R2 row word 0 gives row 73 spare 0", int'(rsp_row), 256);
    access(0, 73, 20, 0);
    chk("R9 spare row read back", int'(rsp_rdata), 1);
    access(1, 10, 20, 0);
    chk("R3 row 10 to spare 1", int'(rsp_row), 257);
    chk("R9 write returns zero", int'(rsp_rdata), 0);
    access(1, 5, 1, 0);
    chk("R2 column word 2 gives column 1 spare 0", int'(rsp_col), 256);
    access(0, 9, 5, 0);
    chk("R10 invalid entry leaves column 5", int'(rsp_col), 5);

    access(1, 73, 1, 1);
    chk("R5 crossing row", int'(rsp_row), 256);
    chk("R5 crossing column", int'(rsp_col), 256);
    access(1, 73, 2, 0);
    access(1, 6, 1, 0);
    access(0, 73, 1, 0);
    chk("R5 crossing cell keeps its own bit", int'(rsp_rdata), 1);

    access(0, 8, 5, 0, 1, 1, 1, {1'b1, 1'b1, 8'd5});
    chk("R6 same-edge request uses old map", int'(rsp_col), 5);
    access(0, 8, 5, 0);
    chk("R6 soft entry now applied", int'(rsp_col), 257);

    access(0, 0, 0, 0, 1, 0, 1, {1'b1, 1'b0, 8'd10});
    chk("R7 collision raises row flag", int'(row_cfg_err), 1);
    access(0, 73, 3, 0);
    chk("R7 row table disabled", int'(rsp_row), 73);
    access(0, 8, 1, 0);
    chk("R7 column table still active", int'(rsp_col), 256);
    chk("R7 column flag clear", int'(col_cfg_err), 0);

    access(0, 0, 0, 0, 1, 0, 1, {1'b1, 1'b1, 8'd73});
    access(0, 73, 4, 0);
    chk("R8 lowest index wins", int'(rsp_row), 256);
    chk("R8 no collision flag", int'(row_cfg_err), 0);

    for (int k = 0; k < 3000; k++) begin
      bit dc;
      dc = ($urandom % 8) == 0;
      access(bit'($urandom % 2), pick(), pick(), bit'($urandom % 2),
             dc, bit'($urandom % 2), int'($urandom % NE),
             {bit'($urandom % 4 != 0), bit'($urandom % 2), hot[$urandom % 4][7:0]});
      if ($urandom % 10 == 0) begin
        @(negedge clk);
        chk("R9 no beat without request", int'(rsp_valid), 0);
      end
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errs++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule